// File: doc/BRIEF.md
# Horizontal Fine-Pan Shift Generator with Split-Screen Override

This block produces the number of pixel positions by which the pixel serializer shifts the picture left on every scan line. Software programs a pixel-pan field, a pair of byte-pan extension bits and a shift-mode select. Writes land in a staging register and are copied to the working register only at the start of a scan line, so a line is never panned by two values.

A split screen is supported. When the split-compatibility enable is set and the raster reaches the line-compare row, a one-cycle match pulse forces the shift to zero. The region below the split point then appears unpanned. The force stays in effect until the next vertical-sync pulse, after which the programmed pan returns.

The block also checks one configuration rule. In double-scanned 200-line modes the line-compare value must be even, and an odd value is flagged on a configuration error output.

Top module: `fine_pan_unit`

## Requirements
- R1: With shift mode 0 (single byte) or the unused code 3, `pan_shift` equals the 3-bit pixel-pan field (0 to 7), and the byte-pan bits are ignored.
- R2: With shift mode 1 (16-bit), `pan_shift` equals {byte_pan[0], pel_pan}, a value from 0 to 15, and byte_pan[1] is ignored.
- R3: With shift mode 2 (32-bit), `pan_shift` equals {byte_pan[1:0], pel_pan}, a value from 0 to 31.
- R4: When `lc_hit` is high in a cycle while `compat_en` is high and `vsync` is low, `pan_shift` reads zero from the next cycle onward.
- R5: A `vsync` pulse ends the forced-zero state from the next cycle, restoring the programmed pan. A `vsync` in the same cycle as a hit wins, so no force results.
- R6: While `compat_en` is low, an `lc_hit` pulse leaves `pan_shift` unchanged.
- R7: A `pan_wr` pulse stores pel_pan_in, byte_pan_in and shift_mode_in in a staging register. The staged values reach `pan_shift` only in the cycle after a `line_start` pulse. A write in the same cycle as `line_start` waits for the following `line_start`.
- R8: `cfg_err` is high, combinationally, exactly when `double_scan` is high and `lc_value` bit 0 is 1.
- R9: Reset clears the staging register, the working register and the override flag, so `pan_shift` is zero during reset and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| pan_wr | input | 1 | Write strobe for the pan fields |
| pel_pan_in | input | 3 | Pixel-pan field |
| byte_pan_in | input | 2 | Byte-pan extension bits |
| shift_mode_in | input | 2 | 0 single byte, 1 16-bit, 2 32-bit, 3 treated as 0 |
| line_start | input | 1 | One-cycle pulse at the start of each scan line |
| compat_en | input | 1 | Enables the split-screen pan override |
| lc_hit | input | 1 | One-cycle line-compare match pulse |
| vsync | input | 1 | One-cycle vertical-sync pulse |
| double_scan | input | 1 | High in double-scanned 200-line modes |
| lc_value | input | LC_W | Programmed line-compare value |
| pan_shift | output | 5 | Shift amount for the pixel serializer |
| cfg_err | output | 1 | Odd line-compare value in double-scan mode |

## Verification
A stuck or wrongly set override flag shows as a zero shift one cycle after the event that should have changed it. Such a fault persists until the next vertical sync, so any later line with a non-zero pan exposes it. A staging fault shows as a shift change in a cycle that does not follow a `line_start`. A mode decode error shows as soon as a working value with non-zero byte-pan bits is applied. The bench compares `pan_shift` against its own model in every cycle, so each of these faults is reported in the first cycle it affects.

// File: rtl/pan_pkg.sv
package pan_pkg;
  localparam int PEL_W   = 3;
  localparam int BYTE_W  = 2;
  localparam int SHIFT_W = PEL_W + BYTE_W;

  typedef enum logic [1:0] {
    MODE_BYTE  = 2'd0,
    MODE_WORD  = 2'd1,
    MODE_DWORD = 2'd2,
    MODE_RSVD  = 2'd3
  } shift_mode_e;

  typedef struct packed {
    logic [PEL_W-1:0]  pel;
    logic [BYTE_W-1:0] byt;
    shift_mode_e       mode;
  } pan_cfg_t;
endpackage

// File: rtl/pan_shadow.sv
module pan_shadow
  import pan_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  pan_cfg_t wr_cfg,
  input  logic     line_start,
  output pan_cfg_t active_cfg
);
  pan_cfg_t staged_q, staged_d;
  pan_cfg_t active_q, active_d;

  always_comb begin
    staged_d = staged_q;
    active_d = active_q;
    if (wr_en)      staged_d = wr_cfg;
    if (line_start) active_d = staged_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= '0;
      active_q <= '0;
    end else begin
      staged_q <= staged_d;
      active_q <= active_d;
    end
  end

  assign active_cfg = active_q;

  AST_HOLD_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(active_q)); // R7
  AST_LOAD_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (active_q == $past(staged_q))); // R7
endmodule

// File: rtl/pan_compose.sv
module pan_compose
  import pan_pkg::*;
(
  input  pan_cfg_t             cfg,
  output logic [SHIFT_W-1:0]   shift
);
  always_comb begin
    unique case (cfg.mode)
      MODE_WORD:  shift = SHIFT_W'({cfg.byt[0], cfg.pel});
      MODE_DWORD: shift = SHIFT_W'({cfg.byt, cfg.pel});
      default:    shift = SHIFT_W'(cfg.pel);
    endcase
  end
endmodule

// File: rtl/split_override.sv
module split_override (
  input  logic clk,
  input  logic rst_n,
  input  logic compat_en,
  input  logic lc_hit,
  input  logic vsync,
  output logic force_zero
);
  logic ovr_q, ovr_d;

  always_comb begin
    ovr_d = ovr_q;
    if (vsync)                  ovr_d = 1'b0;
    else if (lc_hit && compat_en) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign force_zero = ovr_q;

  AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_hit && compat_en && !vsync) |=> ovr_q); // R4
  AST_VSYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> !ovr_q); // R5
  AST_COMPAT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!compat_en && !ovr_q) |=> !ovr_q); // R6
endmodule

// File: rtl/fine_pan_unit.sv
module fine_pan_unit
  import pan_pkg::*;
#(
  parameter int LC_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pan_wr,
  input  logic [PEL_W-1:0]   pel_pan_in,
  input  logic [BYTE_W-1:0]  byte_pan_in,
  input  logic [1:0]         shift_mode_in,
  input  logic               line_start,
  input  logic               compat_en,
  input  logic               lc_hit,
  input  logic               vsync,
  input  logic               double_scan,
  input  logic [LC_W-1:0]    lc_value,
  output logic [SHIFT_W-1:0] pan_shift,
  output logic               cfg_err
);
  pan_cfg_t           wr_cfg;
  pan_cfg_t           active_cfg;
  logic [SHIFT_W-1:0] composed;
  logic               force_zero;

  always_comb begin
    wr_cfg.pel  = pel_pan_in;
    wr_cfg.byt  = byte_pan_in;
    wr_cfg.mode = shift_mode_e'(shift_mode_in);
  end

  pan_shadow u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (pan_wr),
    .wr_cfg     (wr_cfg),
    .line_start (line_start),
    .active_cfg (active_cfg)
  );

  pan_compose u_compose (
    .cfg   (active_cfg),
    .shift (composed)
  );

  split_override u_ovr (
    .clk        (clk),
    .rst_n      (rst_n),
    .compat_en  (compat_en),
    .lc_hit     (lc_hit),
    .vsync      (vsync),
    .force_zero (force_zero)
  );

  assign pan_shift = force_zero ? '0 : composed;
  assign cfg_err   = double_scan & lc_value[0];

  AST_ZERO_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_hit && compat_en && !vsync) |=> (pan_shift == '0)); // R4
  AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((active_cfg.mode == MODE_BYTE) || (active_cfg.mode == MODE_RSVD)) |-> (pan_shift < 8)); // R1
  AST_WORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_cfg.mode == MODE_WORD) |-> (pan_shift < 16)); // R2
  AST_ERR_NEEDS_DS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> double_scan); // R8
endmodule

// File: tb/fine_pan_unit_test.sv
`timescale 1ns/100ps
module fine_pan_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pan_wr, line_start, compat_en, lc_hit, vsync, double_scan;
  logic [2:0] pel_pan_in;
  logic [1:0] byte_pan_in, shift_mode_in;
  logic [9:0] lc_value;
  logic [4:0] pan_shift;
  logic       cfg_err;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [2:0] m_stg_pel, m_act_pel;
  logic [1:0] m_stg_byt, m_act_byt, m_stg_mode, m_act_mode;
  logic       m_ovr;

  always #2.5 clk = ~clk;

  fine_pan_unit #(.LC_W(10)) uut (
    .clk(clk), .rst_n(rst_n), .pan_wr(pan_wr), .pel_pan_in(pel_pan_in),
    .byte_pan_in(byte_pan_in), .shift_mode_in(shift_mode_in),
    .line_start(line_start), .compat_en(compat_en), .lc_hit(lc_hit),
    .vsync(vsync), .double_scan(double_scan), .lc_value(lc_value),
    .pan_shift(pan_shift), .cfg_err(cfg_err)
  );

  function automatic logic [4:0] calc_shift(logic [2:0] p, logic [1:0] b, logic [1:0] m);
    case (m)
      2'd1:    return {1'b0, b[0], p};
      2'd2:    return {b, p};
      default: return {2'b00, p};
    endcase
  endfunction

  function automatic logic [4:0] exp_shift();
    return m_ovr ? 5'd0 : calc_shift(m_act_pel, m_act_byt, m_act_mode);
  endfunction

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string shift_tag();
    if (m_ovr) return "R4";
    case (m_act_mode)
      2'd1:    return "R2";
      2'd2:    return "R3";
      default: return "R1";
    endcase
  endfunction

  task automatic model_reset();
    m_stg_pel = 0; m_stg_byt = 0; m_stg_mode = 0;
    m_act_pel = 0; m_act_byt = 0; m_act_mode = 0; m_ovr = 0;
  endtask

  task automatic idle_inputs();
    pan_wr = 0; line_start = 0; lc_hit = 0; vsync = 0;
  endtask

  // One clock: model follows the inputs at posedge, outputs are checked at negedge.
  task automatic tick(string tag);
    @(posedge clk);
    if (line_start) begin
      m_act_pel = m_stg_pel; m_act_byt = m_stg_byt; m_act_mode = m_stg_mode;
    end
    if (pan_wr) begin
      m_stg_pel = pel_pan_in; m_stg_byt = byte_pan_in; m_stg_mode = shift_mode_in;
    end
    if (vsync) m_ovr = 1'b0;
    else if (lc_hit && compat_en) m_ovr = 1'b1;
    @(negedge clk);
    check(tag == "" ? shift_tag() : tag, pan_shift, exp_shift());
    n_chk++;
    if (cfg_err !== (double_scan & lc_value[0])) begin
      n_fail++;
      $display("FAIL R8: cfg_err actual %0b expected %0b", cfg_err, double_scan & lc_value[0]);
    end
  endtask

  task automatic program_pan(logic [2:0] p, logic [1:0] b, logic [1:0] m);
    pan_wr = 1; pel_pan_in = p; byte_pan_in = b; shift_mode_in = m;
    tick("R7");
    pan_wr = 0;
    line_start = 1;
    tick("R7");
    line_start = 0;
    tick("");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 0; idle_inputs();
    compat_en = 0; double_scan = 0; lc_value = 0;
    pel_pan_in = 0; byte_pan_in = 0; shift_mode_in = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R9", pan_shift, 5'd0);
    rst_n = 1;
    tick("R9");

    // Directed: mode decodes, byte bits ignored in narrow modes
    program_pan(3'd5, 2'd3, 2'd0); check("R1", pan_shift, 5'd5);
    program_pan(3'd7, 2'd3, 2'd3); check("R1", pan_shift, 5'd7);
    program_pan(3'd6, 2'd3, 2'd1); check("R2", pan_shift, 5'd14);
    program_pan(3'd7, 2'd3, 2'd2); check("R3", pan_shift, 5'd31);

    // Directed: write lands mid-line, same cycle as line_start
    pan_wr = 1; pel_pan_in = 3'd1; byte_pan_in = 0; shift_mode_in = 2'd2; line_start = 1;
    tick("R7");
    idle_inputs();
    check("R7", pan_shift, 5'd31);
    tick("R7"); check("R7", pan_shift, 5'd31);
    line_start = 1; tick("R7"); line_start = 0;
    check("R7", pan_shift, 5'd1);

    // Directed: override with compat off, on, and vsync priority
    compat_en = 0; lc_hit = 1; tick("R6"); lc_hit = 0;
    check("R6", pan_shift, 5'd1);
    compat_en = 1; lc_hit = 1; vsync = 1; tick("R5"); idle_inputs();
    check("R5", pan_shift, 5'd1);
    lc_hit = 1; tick("R4"); lc_hit = 0;
    check("R4", pan_shift, 5'd0);
    line_start = 1; tick("R4"); line_start = 0;
    check("R4", pan_shift, 5'd0);
    vsync = 1; tick("R5"); vsync = 0;
    check("R5", pan_shift, 5'd1);

    // Directed: configuration error
    double_scan = 1; lc_value = 10'd201; tick("R8");
    lc_value = 10'd200; tick("R8");
    double_scan = 0; lc_value = 10'd201; tick("R8");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      pan_wr        = ($urandom % 5) == 0;
      pel_pan_in    = 3'($urandom);
      byte_pan_in   = 2'($urandom);
      shift_mode_in = 2'($urandom);
      line_start    = ($urandom % 8) == 0;
      lc_hit        = ($urandom % 20) == 0;
      vsync         = ($urandom % 40) == 0;
      if (($urandom % 50) == 0) compat_en = ~compat_en;
      double_scan   = 1'($urandom);
      lc_value      = 10'($urandom);
      tick("");
    end
    idle_inputs();

    // Reset in mid-run clears everything
    program_pan(3'd3, 2'd2, 2'd2);
    compat_en = 1; lc_hit = 1; tick("R4"); lc_hit = 0;
    rst_n = 0; model_reset();
    @(negedge clk); check("R9", pan_shift, 5'd0);
    rst_n = 1;
    line_start = 1; tick("R9"); line_start = 0;
    check("R9", pan_shift, 5'd0);

    finish_run();
  end
endmodule